// File: doc/BRIEF.md
# Keyboard Controller Host Port

This block is the register window a host CPU uses to talk to a keyboard controller. One address-select line picks between two register pairs. With select low, the host reads the received keyboard byte and writes a data byte bound for the keyboard. With select high, the host reads a status byte and writes a command byte. Behind the data register there is exactly one byte of storage and no queue. A received byte stays in place however many times it is read, until a fresh byte replaces it.

Keyboard bytes arrive on a valid/ready stream. The port raises ready only while its output buffer is empty and the keyboard is enabled. Back-pressure is therefore the only flow control: a producer holding valid simply waits, and the port never drops or overwrites a buffered byte. Host data writes leave through a second valid/ready stream toward the keyboard link. That stream holds its byte and valid steady until ready is seen. Host command writes are consumed inside the block: one code disables keyboard loading, another enables it again, and every other code is swallowed with no effect.

An interrupt request follows the output-full flag, gated by a plain enable pin.

Top module: `kbc_host_port`

## Requirements
- R1: A host read with `hst_sel`=0 returns the output data byte and one with `hst_sel`=1 returns the status byte; a host write with `hst_sel`=0 is a data write and with `hst_sel`=1 a command write (a data write of 0xAD does not disable).
- R2: Status bit 0 is output-full (OBF), bit 1 is input-full (IBF), bits 7..2 always read 0.
- R3: A keyboard byte accepted at a clock edge (`kb_valid` and `kb_ready` high) is in the data register with OBF=1 from the next cycle; a data read (`hst_rd`, `hst_sel`=0) with OBF set clears OBF at the next cycle.
- R4: `kb_ready` is low whenever OBF is set, so no byte can be loaded over an unread one.
- R5: Data reads do not change the data register: repeated reads return the same byte. Status reads change no state.
- R6: Command 0xAD drops `kb_ready` and keeps it low until command 0xAE; the buffered byte stays readable meanwhile.
- R7: A host write accepted while IBF=0 sets IBF at the next cycle; a command write is consumed one cycle later, clearing IBF.
- R8: A data write appears on `dw_valid`/`dw_data`, held stable while `dw_ready` is low; IBF clears the cycle after the handshake.
- R9: A host write (data or command) made while IBF=1 is dropped entirely.
- R10: Any command code other than 0xAD and 0xAE clears IBF and leaves the enable state unchanged.
- R11: `irq` equals OBF AND `irq_en`.
- R12: After reset OBF=0, IBF=0, the data register is 0x00, and the keyboard is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Address select: 0 data, 1 status/command |
| hst_rd | input | 1 | Single-cycle host read strobe |
| hst_wr | input | 1 | Single-cycle host write strobe |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| kb_valid | input | 1 | Keyboard byte offered |
| kb_data | input | 8 | Keyboard byte |
| kb_ready | output | 1 | Port can accept a keyboard byte |
| dw_valid | output | 1 | Host data byte pending toward keyboard |
| dw_data | output | 8 | Pending host data byte |
| dw_ready | input | 1 | Keyboard side takes the pending byte |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that host strobes are single-cycle pulses, that read and write never coincide, and that `kb_data` stays steady while `kb_valid` waits on `kb_ready`. The stimulus drives every input at the falling edge from tasks that raise one strobe per cycle. Its producer task holds valid and data until ready is seen. The bench sweeps all 256 keyboard byte values through load, repeated status reads and repeated data reads, and all 256 command codes through the decoder. It then steers the disable, dropped-write and stalled-stream corners by hand.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned KBC_DW      = 8;
  localparam int unsigned ST_OBF_BIT  = 0;
  localparam int unsigned ST_IBF_BIT  = 1;
  localparam logic [KBC_DW-1:0] CMD_KB_OFF = 8'hAD;
  localparam logic [KBC_DW-1:0] CMD_KB_ON  = 8'hAE;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_OFF = 2'd1,
    CMD_ON  = 2'd2
  } cmd_act_e;
endpackage

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kb_valid,
  input  logic [DW-1:0] kb_data,
  output logic          kb_ready,
  input  logic          kb_off,
  input  logic          rd_data,
  output logic          obf,
  output logic [DW-1:0] obuf
);
  logic          obf_q;
  logic [DW-1:0] obuf_q;
  logic          take;

  assign kb_ready = !obf_q && !kb_off;
  assign take     = kb_valid && kb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf_q  <= 1'b0;
      obuf_q <= '0;
    end else if (take) begin
      obf_q  <= 1'b1;
      obuf_q <= kb_data;
    end else if (rd_data) begin
      obf_q  <= 1'b0;
    end
  end

  assign obf  = obf_q;
  assign obuf = obuf_q;

  AST_LOAD_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (obf_q && obuf_q == $past(kb_data))); // R3
  AST_READ_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && obf_q) |=> !obf_q); // R3
  AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    obf_q |-> !kb_ready); // R4
  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(obuf_q)); // R5
  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    kb_off |-> !kb_ready); // R6
endmodule

// File: rtl/kbc_inbuf.sv
module kbc_inbuf
  import kbc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] OFF_CODE = 8'hAD,
  parameter logic [DW-1:0] ON_CODE  = 8'hAE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic          hst_sel,
  input  logic [DW-1:0] hst_wdata,
  output logic          ibf,
  output logic          kb_off,
  output logic          dw_valid,
  output logic [DW-1:0] dw_data,
  input  logic          dw_ready
);
  logic          ibf_q;
  logic          is_cmd_q;
  logic [DW-1:0] pend_q;
  logic          off_q;
  cmd_act_e      act;

  always_comb begin
    if (pend_q == OFF_CODE)      act = CMD_OFF;
    else if (pend_q == ON_CODE)  act = CMD_ON;
    else                         act = CMD_NOP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf_q    <= 1'b0;
      is_cmd_q <= 1'b0;
      pend_q   <= '0;
      off_q    <= 1'b0;
    end else if (ibf_q) begin
      if (is_cmd_q) begin
        ibf_q <= 1'b0;
        case (act)
          CMD_OFF: off_q <= 1'b1;
          CMD_ON:  off_q <= 1'b0;
          default: off_q <= off_q;
        endcase
      end else if (dw_ready) begin
        ibf_q <= 1'b0;
      end
    end else if (hst_wr) begin
      ibf_q    <= 1'b1;
      is_cmd_q <= hst_sel;
      pend_q   <= hst_wdata;
    end
  end

  assign ibf      = ibf_q;
  assign kb_off   = off_q;
  assign dw_valid = ibf_q && !is_cmd_q;
  assign dw_data  = pend_q;

  AST_WRITE_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !ibf_q) |=> ibf_q); // R7
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && is_cmd_q) |=> !ibf_q); // R7
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && !dw_ready) |=> (dw_valid && $stable(dw_data))); // R8
  AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_q |=> $stable(pend_q)); // R9
  AST_OTHER_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && is_cmd_q && act == CMD_NOP) |=> $stable(off_q)); // R10
endmodule

// File: rtl/kbc_rdmux.sv
module kbc_rdmux
  import kbc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          hst_sel,
  input  logic          obf,
  input  logic          ibf,
  input  logic [DW-1:0] obuf,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] status;

  for (genvar b = 0; b < DW; b++) begin : g_st
    if (b == ST_OBF_BIT)      begin : g_o assign status[b] = obf; end
    else if (b == ST_IBF_BIT) begin : g_i assign status[b] = ibf; end
    else                      begin : g_z assign status[b] = 1'b0; end
  end

  assign rdata = hst_sel ? status : obuf;
endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
  import kbc_pkg::*;
#(
  parameter int unsigned DW = KBC_DW,
  parameter logic [DW-1:0] OFF_CODE = CMD_KB_OFF,
  parameter logic [DW-1:0] ON_CODE  = CMD_KB_ON
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_sel,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  input  logic          kb_valid,
  input  logic [DW-1:0] kb_data,
  output logic          kb_ready,
  output logic          dw_valid,
  output logic [DW-1:0] dw_data,
  input  logic          dw_ready,
  input  logic          irq_en,
  output logic          irq
);
  logic          obf, ibf, kb_off;
  logic [DW-1:0] obuf;
  logic          rd_data;

  assign rd_data = hst_rd && !hst_sel;

  kbc_outbuf #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
    .kb_off(kb_off), .rd_data(rd_data),
    .obf(obf), .obuf(obuf)
  );

  kbc_inbuf #(.DW(DW), .OFF_CODE(OFF_CODE), .ON_CODE(ON_CODE)) u_in (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_sel(hst_sel), .hst_wdata(hst_wdata),
    .ibf(ibf), .kb_off(kb_off),
    .dw_valid(dw_valid), .dw_data(dw_data), .dw_ready(dw_ready)
  );

  kbc_rdmux #(.DW(DW)) u_rd (
    .hst_sel(hst_sel), .obf(obf), .ibf(ibf), .obuf(obuf), .rdata(hst_rdata)
  );

  assign irq = obf && irq_en;

  AST_STATUS_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && hst_sel && !(kb_valid && kb_ready)) |=> (obf == $past(obf))); // R5
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (hst_sel ? hst_rdata[ST_OBF_BIT] : 1'b1)); // R11
  AST_DATA_READ_SEES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_sel) |=> $stable(obuf) || $past(kb_valid && kb_ready)); // R1
endmodule

// File: tb/kbc_host_port_bench.sv
module kbc_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_sel = 1'b0, hst_rd = 1'b0, hst_wr = 1'b0;
  logic [7:0] hst_wdata = '0, hst_rdata;
  logic       kb_valid = 1'b0, kb_ready;
  logic [7:0] kb_data = '0;
  logic       dw_valid, dw_ready = 1'b0;
  logic [7:0] dw_data;
  logic       irq_en = 1'b0, irq;
  int         nvec = 0, nbad = 0;
  logic [7:0] got;
  logic       exp_off;

  always #10 clk = ~clk;

  kbc_host_port u_kbc_host_port (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .kb_valid(kb_valid), .kb_data(kb_data),
    .kb_ready(kb_ready), .dw_valid(dw_valid), .dw_data(dw_data), .dw_ready(dw_ready),
    .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_read(input logic sel, output logic [7:0] d);
    hst_sel = sel; hst_rd = 1'b1;
    #1 d = hst_rdata;
    @(negedge clk); hst_rd = 1'b0;
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    hst_sel = sel; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic kb_push(input logic [7:0] d);
    kb_valid = 1'b1; kb_data = d;
    while (!kb_ready) @(negedge clk);
    @(negedge clk); kb_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_en = 1'b1;
    #1;
    chk("R12 kb_ready", kb_ready, 1);
    chk("R11 irq empty", irq, 0);
    host_read(1'b1, got); chk("R12 status", got, 0);
    host_read(1'b0, got); chk("R12 data", got, 0);

    for (int v = 0; v < 256; v++) begin
      irq_en = v[0];
      kb_push(8'(v));
      #1;
      chk("R4 ready while full", kb_ready, 0);
      chk("R11 irq", irq, v & 1);
      host_read(1'b1, got); chk("R2 status full", got, 1);
      host_read(1'b1, got); chk("R5 status inert", got, 1);
      host_read(1'b0, got); chk("R3 data", got, v);
      host_read(1'b1, got); chk("R3 obf cleared", got, 0);
      host_read(1'b0, got); chk("R5 reread", got, v);
      #1 chk("R11 irq clear", irq, 0);
    end
    irq_en = 1'b1;

    exp_off = 1'b0;
    for (int c = 0; c < 256; c++) begin
      host_write(1'b1, 8'(c));
      host_read(1'b1, got); chk("R7 ibf set", got, 2);
      host_read(1'b1, got); chk("R7 ibf consumed", got, 0);
      if (c == 'hAD) exp_off = 1'b1;
      else if (c == 'hAE) exp_off = 1'b0;
      #1 chk("R10 enable state", kb_ready, !exp_off);
    end
    chk("R6 off after sweep", kb_ready, 1);

    kb_push(8'h5A);
    host_write(1'b1, 8'hAD);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = 8'hC3;
    host_read(1'b0, got); chk("R6 held byte", got, 8'h5A);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 chk("R6 disabled ready", kb_ready, 0);
    end
    host_read(1'b0, got); chk("R6 held byte again", got, 8'h5A);
    host_read(1'b1, got); chk("R6 no load while off", got, 0);
    kb_valid = 1'b0;
    host_write(1'b1, 8'hAE);
    @(negedge clk);
    kb_push(8'hC3);
    host_read(1'b0, got); chk("R6 load after on", got, 8'hC3);

    host_write(1'b0, 8'hAD);
    #1 chk("R8 valid", dw_valid, 1);
    chk("R8 data", dw_data, 8'hAD);
    host_write(1'b0, 8'h11);
    host_write(1'b1, 8'hAD);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 chk("R8 hold data", dw_data, 8'hAD);
      chk("R8 hold valid", dw_valid, 1);
    end
    host_read(1'b1, got); chk("R8 ibf while stalled", got, 2);
    dw_ready = 1'b1;
    @(negedge clk); dw_ready = 1'b0;
    #1 chk("R8 valid drops", dw_valid, 0);
    host_read(1'b1, got); chk("R8 ibf clear", got, 0);
    @(negedge clk); #1 chk("R9 dropped command", dw_valid, 0);
    chk("R1 data write not command", kb_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule